// File: doc/BRIEF.md
# Table-Driven Disk Bit Sequencer

This block is a small programmable state machine that carries bytes between a processor and a serial disk bit stream. Each enabled clock it performs one step. It fetches one byte from a 256-entry program memory at the current 8-bit state word. The low four bits of that byte pick an operation on an 8-bit data register. The high bits, together with live status, form the next state word: the read pulse, the two mode flags and the data register MSB. Bit 7 of the state word drives a write line toward the drive. Every change of that line is counted as a transition event.

The program memory is filled through a plain write port while the sequencer is disabled. The processor side writes a byte that the program can load, reads the data register back, and uses four control strobes to set and clear the load and write modes. A rising edge of the enable input restarts the sequencer. Every later cycle with enable high is one step.

Top module: `disk_seq_top`

## Requirements
- R1: A step fetches the program byte at {state[7:5], pulse status, state[3:0]}. The next state takes bits 7:6 from fetched bits 7:6, bit 5 from fetched bit 4 and bit 0 from fetched bit 5. Bit 4 takes the pulse status, and bits 3:2 take the mode flags.
- R2: After every step, state bit 1 equals bit 7 of the new data register.
- R3: Fetched low nibbles 0 to 7 clear the data register. Nibbles 8 and 12 leave it unchanged.
- R4: Nibble 9 shifts the data register left and inserts 0 at bit 0. Nibble 13 shifts it left and inserts 1.
- R5: Nibbles 10 and 14 shift the data register right, and the write-protect level enters bit 7.
- R6: Nibbles 11 and 15 load the byte most recently written by the processor. A write in the same cycle is not yet visible.
- R7: A rising edge of the read pulse input makes the pulse status 0 for exactly one step. The status is 1 at every other step, even while the input stays high.
- R8: After a step the write line equals state bit 7. Each change of the write line raises the event output for one cycle.
- R9: Control strobe codes: 0 clears load mode (state bit 2), 1 sets it, 2 clears write mode (state bit 3), 3 sets it. They act whether or not the sequencer is stepping.
- R10: A processor read with the odd flag low returns the data register in the next cycle. With the odd flag high it returns 0xFF.
- R11: On a rising edge of enable, the data register becomes 0x00, state bits 3:1 become 0, the write line goes low and the event count resets. No operation is executed in that cycle.
- R12: The event count saturates at EVT_MAX. The flush input resets it, and a toggle in the flush cycle counts as 1.
- R13: Reset sets the state word, data register, write line, count and read data to zero. With enable low no step occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Run enable; rising edge restarts |
| rd_pulse_i | input | 1 | Read pulse from drive |
| wp_i | input | 1 | Write-protect level |
| cpu_wr_i | input | 1 | Processor byte write strobe |
| cpu_wdata_i | input | DW | Processor write byte |
| cpu_rd_i | input | 1 | Processor read strobe |
| cpu_rd_odd_i | input | 1 | Read offset is odd |
| ctl_valid_i | input | 1 | Control strobe valid |
| ctl_sel_i | input | 2 | Control strobe code |
| prog_we_i | input | 1 | Program memory write enable |
| prog_addr_i | input | AW | Program memory write address |
| prog_data_i | input | DW | Program memory write data |
| evt_flush_i | input | 1 | Reset the transition event count |
| data_o | output | DW | Data register |
| rd_data_o | output | DW | Registered processor read data |
| addr_o | output | AW | Current state word |
| wl_o | output | 1 | Write line |
| wl_evt_o | output | 1 | Write line changed in the last step |
| evt_count_o | output | $clog2(EVT_MAX+1) | Transition events since the last flush |

## Verification
The bench builds the block with EVT_MAX set to 4, so the event counter saturates within a few toggles. Flushes during long runs then land both before and after the cap. The 8-bit state word and data width stay at their defaults, so a computed program fills all 256 entries. That program uses every one of the sixteen operation nibbles and many state words, so a few thousand steps under varied pulse, mode and processor stimulus cover them all. A second program that flips bit 7 on every step drives the write line and the counter to their limits.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int ST_BIT0    = 0;
  localparam int ST_MSB     = 1;
  localparam int ST_LOAD    = 2;
  localparam int ST_WRITE   = 3;
  localparam int ST_PULSE   = 4;
  localparam int ST_BIT5    = 5;
  localparam int ST_WLINE   = 7;

  typedef enum logic [1:0] {
    CTL_LOAD_OFF  = 2'd0,
    CTL_LOAD_ON   = 2'd1,
    CTL_WRITE_OFF = 2'd2,
    CTL_WRITE_ON  = 2'd3
  } ctl_code_e;
endpackage

// File: rtl/seq_prog_ram.sv
module seq_prog_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // combinational read: the fetch address depends on this cycle's status
  assign rdata = mem[raddr];
endmodule

// File: rtl/seq_data_alu.sv
module seq_data_alu #(
  parameter int DW = 8
) (
  input  logic [3:0]    code,
  input  logic [DW-1:0] cur,
  input  logic          wp,
  input  logic [DW-1:0] host_byte,
  output logic [DW-1:0] nxt
);
  always_comb begin
    if (!code[3]) begin
      nxt = '0;
    end else begin
      unique case (code[1:0])
        2'b00: nxt = cur;
        2'b01: nxt = {cur[DW-2:0], code[2]};
        2'b10: nxt = {wp, cur[DW-1:1]};
        default: nxt = host_byte;
      endcase
    end
  end
endmodule

// File: rtl/seq_wline.sv
module seq_wline #(
  parameter int EVT_MAX = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         step,
  input  logic                         target,
  input  logic                         flush,
  output logic                         wl_o,
  output logic                         evt_o,
  output logic [$clog2(EVT_MAX+1)-1:0] cnt_o
);
  localparam int CNT_W = $clog2(EVT_MAX+1);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(EVT_MAX);

  logic toggle;
  assign toggle = step && (wl_o != target);

  always_ff @(posedge clk) begin
    if (rst) begin
      wl_o  <= 1'b0;
      evt_o <= 1'b0;
      cnt_o <= '0;
    end else if (start) begin
      wl_o  <= 1'b0;
      evt_o <= 1'b0;
      cnt_o <= '0;
    end else begin
      evt_o <= toggle;
      if (toggle) wl_o <= ~wl_o;
      if (flush)
        cnt_o <= toggle ? CNT_W'(1) : '0;
      else if (toggle && cnt_o < CAP)
        cnt_o <= cnt_o + 1'b1;
    end
  end

  assert_count_capped_R12: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= CAP);

  assert_event_marks_change_R8: assert property (@(posedge clk) disable iff (rst)
    (step && !start && !flush && wl_o != target && cnt_o < CAP) |=> (evt_o && cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/disk_seq_top.sv
module disk_seq_top #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int EVT_MAX = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable_i,
  input  logic                         rd_pulse_i,
  input  logic                         wp_i,
  input  logic                         cpu_wr_i,
  input  logic [DW-1:0]                cpu_wdata_i,
  input  logic                         cpu_rd_i,
  input  logic                         cpu_rd_odd_i,
  input  logic                         ctl_valid_i,
  input  logic [1:0]                   ctl_sel_i,
  input  logic                         prog_we_i,
  input  logic [AW-1:0]                prog_addr_i,
  input  logic [DW-1:0]                prog_data_i,
  input  logic                         evt_flush_i,
  output logic [DW-1:0]                data_o,
  output logic [DW-1:0]                rd_data_o,
  output logic [AW-1:0]                addr_o,
  output logic                         wl_o,
  output logic                         wl_evt_o,
  output logic [$clog2(EVT_MAX+1)-1:0] evt_count_o
);
  import seq_pkg::*;

  logic [AW-1:0] state_q;
  logic [DW-1:0] data_q, host_q;
  logic          en_q, pulse_q;
  logic          start, step, edge_seen;
  logic [AW-1:0] fetch_addr, state_step;
  logic [DW-1:0] fetched, data_nxt;
  logic          load_n, write_n;

  assign start     = enable_i && !en_q;
  assign step      = enable_i && en_q;
  assign edge_seen = rd_pulse_i && !pulse_q;

  always_comb begin
    fetch_addr           = state_q;
    fetch_addr[ST_PULSE] = ~edge_seen;
  end

  always_comb begin
    load_n  = state_q[ST_LOAD];
    write_n = state_q[ST_WRITE];
    if (ctl_valid_i) begin
      unique case (ctl_code_e'(ctl_sel_i))
        CTL_LOAD_OFF:  load_n  = 1'b0;
        CTL_LOAD_ON:   load_n  = 1'b1;
        CTL_WRITE_OFF: write_n = 1'b0;
        default:       write_n = 1'b1;
      endcase
    end
  end

  seq_prog_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (prog_we_i),
    .waddr (prog_addr_i),
    .wdata (prog_data_i),
    .raddr (fetch_addr),
    .rdata (fetched)
  );

  seq_data_alu #(.DW(DW)) u_alu (
    .code      (fetched[3:0]),
    .cur       (data_q),
    .wp        (wp_i),
    .host_byte (host_q),
    .nxt       (data_nxt)
  );

  always_comb begin
    state_step           = state_q;
    state_step[7:6]      = fetched[7:6];
    state_step[ST_BIT5]  = fetched[4];
    state_step[ST_PULSE] = ~edge_seen;
    state_step[ST_WRITE] = write_n;
    state_step[ST_LOAD]  = load_n;
    state_step[ST_MSB]   = data_nxt[DW-1];
    state_step[ST_BIT0]  = fetched[5];
  end

  seq_wline #(.EVT_MAX(EVT_MAX)) u_wline (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .step   (step),
    .target (state_step[ST_WLINE]),
    .flush  (evt_flush_i),
    .wl_o   (wl_o),
    .evt_o  (wl_evt_o),
    .cnt_o  (evt_count_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= '0;
      data_q    <= '0;
      host_q    <= '0;
      en_q      <= 1'b0;
      pulse_q   <= 1'b0;
      rd_data_o <= '0;
    end else begin
      en_q    <= enable_i;
      pulse_q <= rd_pulse_i;
      if (cpu_wr_i) host_q <= cpu_wdata_i;
      if (cpu_rd_i) rd_data_o <= cpu_rd_odd_i ? '1 : data_q;
      if (start) begin
        data_q       <= '0;
        state_q[3:1] <= 3'b000;
      end else if (step) begin
        data_q  <= data_nxt;
        state_q <= state_step;
      end else begin
        state_q[ST_WRITE] <= write_n;
        state_q[ST_LOAD]  <= load_n;
      end
    end
  end

  assign data_o = data_q;
  assign addr_o = state_q;

  assert_msb_mirror_R2: assert property (@(posedge clk) disable iff (rst)
    step |=> (addr_o[ST_MSB] == data_o[DW-1]));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    (step && rd_pulse_i && pulse_q) |=> addr_o[ST_PULSE]);

  assert_line_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (step && !start) |=> (wl_o == addr_o[ST_WLINE]));

  assert_odd_read_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_i && cpu_rd_odd_i) |=> (rd_data_o == '1));

  assert_start_clear_R11: assert property (@(posedge clk) disable iff (rst)
    start |=> (data_o == '0 && addr_o[3:1] == 3'b000 && !wl_o));

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (!enable_i && !ctl_valid_i) |=> ($stable(addr_o) && $stable(data_o)));
endmodule

// File: tb/tb_disk_seq_top.sv
`timescale 1ns/1ps
module tb_disk_seq_top;
  localparam int EMAX = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable_i = 0, rd_pulse_i = 0, wp_i = 0, cpu_wr_i = 0, cpu_rd_i = 0, cpu_rd_odd_i = 0;
  logic ctl_valid_i = 0, prog_we_i = 0, evt_flush_i = 0;
  logic [1:0] ctl_sel_i = 0;
  logic [7:0] cpu_wdata_i = 0, prog_addr_i = 0, prog_data_i = 0;
  logic [7:0] data_o, rd_data_o, addr_o;
  logic wl_o, wl_evt_o;
  logic [2:0] evt_count_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  disk_seq_top #(.AW(8), .DW(8), .EVT_MAX(EMAX)) dut (.*);

  // independent model state
  logic [7:0] m_mem [256];
  logic [7:0] m_addr = 0, m_data = 0, m_host = 0, m_rd = 0;
  logic m_enq = 0, m_pq = 0, m_wl = 0, m_evt = 0;
  logic [2:0] m_cnt = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
    return lfsr;
  endfunction

  // one clock; model updated from the inputs driven before the edge
  task automatic tick(bit cmp);
    logic flux, st, stp, ld, wr;
    logic [7:0] fa, op, nd, na;
    logic [3:0] c;
    string tag;
    flux = rd_pulse_i & ~m_pq;
    st = enable_i & ~m_enq;
    stp = enable_i & m_enq;
    fa = {m_addr[7:5], ~flux, m_addr[3:0]};
    op = m_mem[fa];
    c = op[3:0];
    if (c < 8) begin nd = 8'h00; tag = "R3"; end
    else if (c == 8 || c == 12) begin nd = m_data; tag = "R3"; end
    else if (c == 9) begin nd = m_data * 2; tag = "R4"; end
    else if (c == 13) begin nd = m_data * 2 + 1; tag = "R4"; end
    else if (c == 10 || c == 14) begin nd = m_data / 2 + (wp_i ? 8'd128 : 8'd0); tag = "R5"; end
    else begin nd = m_host; tag = "R6"; end
    ld = m_addr[2]; wr = m_addr[3];
    if (ctl_valid_i) begin
      if (ctl_sel_i == 0) ld = 0; else if (ctl_sel_i == 1) ld = 1;
      else if (ctl_sel_i == 2) wr = 0; else wr = 1;
    end
    na = {op[7:6], op[4], ~flux, wr, ld, nd[7], op[5]};
    @(posedge clk);
    if (prog_we_i) m_mem[prog_addr_i] = prog_data_i;
    if (cpu_rd_i) m_rd = cpu_rd_odd_i ? 8'hFF : m_data;
    if (cpu_wr_i) m_host = cpu_wdata_i;
    m_evt = 0;
    if (st) begin
      m_data = 0; m_addr[3:1] = 0; m_wl = 0; m_cnt = 0;
    end else if (stp) begin
      m_evt = (m_wl != na[7]);
      if (m_evt) m_wl = ~m_wl;
      if (evt_flush_i) m_cnt = m_evt ? 3'd1 : 3'd0;
      else if (m_evt && m_cnt < EMAX) m_cnt++;
      m_data = nd; m_addr = na;
    end else begin
      m_addr[3:2] = {wr, ld};
      if (evt_flush_i) m_cnt = 0;
    end
    m_enq = enable_i; m_pq = rd_pulse_i;
    @(negedge clk);
    if (cmp) begin
      if (stp) check({tag, " data op"}, data_o, m_data);
      else check("R13 data hold", data_o, m_data);
      check("R1 state word", addr_o, m_addr);
      check("R2 msb mirror", addr_o[1], m_addr[1]);
      check("R8 write line", wl_o, m_wl);
      check("R8 event pulse", wl_evt_o, m_evt);
      check("R12 event count", evt_count_o, m_cnt);
      if (cpu_rd_i) check("R10 read data", rd_data_o, m_rd);
      if (st) check("R11 start clear", {data_o, addr_o[3:1], wl_o}, 12'h0);
    end
  endtask

  task automatic quiet();
    cpu_wr_i = 0; cpu_rd_i = 0; ctl_valid_i = 0; evt_flush_i = 0; prog_we_i = 0;
  endtask

  task automatic load_prog(int kind);
    enable_i = 0; quiet();
    for (int a = 0; a < 256; a++) begin
      logic [15:0] h;
      logic [7:0] av;
      av = 8'(a);
      h = 16'(a * 73 + 29);
      prog_we_i = 1; prog_addr_i = av;
      prog_data_i = (kind == 0) ? (h[7:0] ^ {av[3:0], av[7:4]}) : {~av[7], 7'b000_1000};
      tick(0);
    end
    prog_we_i = 0;
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13: reset state
    check("R13 reset data", data_o, 0);
    check("R13 reset state", addr_o, 0);
    check("R13 reset line", wl_o, 0);
    check("R13 reset count", evt_count_o, 0);
    check("R13 reset read", rd_data_o, 0);

    load_prog(0);
    check("R13 no step while disabled", addr_o, 0);

    // R9: mode strobes while idle
    ctl_valid_i = 1; ctl_sel_i = 1; tick(1); check("R9 load on", addr_o[2], 1);
    ctl_sel_i = 3; tick(1); check("R9 write on", addr_o[3], 1);
    ctl_sel_i = 0; tick(1); check("R9 load off", addr_o[2], 0);
    ctl_sel_i = 2; tick(1); check("R9 write off", addr_o[3], 0);
    ctl_valid_i = 0;

    // R10: even/odd processor reads
    cpu_rd_i = 1; cpu_rd_odd_i = 1; tick(1); check("R10 odd read", rd_data_o, 8'hFF);
    cpu_rd_odd_i = 0; tick(1); check("R10 even read", rd_data_o, data_o);
    cpu_rd_i = 0;

    // long mixed sweep over the computed program
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = rnd();
      enable_i = (r[4:0] != 0);
      rd_pulse_i = (r[6:5] == 0);
      wp_i = r[7];
      cpu_wr_i = r[8] & r[9]; cpu_wdata_i = r[17:10];
      cpu_rd_i = r[18] & r[19]; cpu_rd_odd_i = r[20];
      ctl_valid_i = (r[23:21] == 0); ctl_sel_i = r[25:24];
      evt_flush_i = (r[29:26] == 0);
      tick(1);
    end
    quiet();

    // R7: held pulse gives one low status step
    enable_i = 1; rd_pulse_i = 0; tick(1); tick(1);
    rd_pulse_i = 1; tick(1); check("R7 first pulse step", addr_o[4], 0);
    tick(1); check("R7 held pulse", addr_o[4], 1);
    tick(1); check("R7 held pulse again", addr_o[4], 1);
    rd_pulse_i = 0;

    // R11: restart
    enable_i = 0; tick(1);
    enable_i = 1; tick(1);
    check("R11 data cleared", data_o, 0);
    check("R11 bits 3:1 cleared", addr_o[3:1], 0);
    check("R11 line low", wl_o, 0);

    // R12/R8: program toggling bit 7 every step
    load_prog(1);
    enable_i = 1; tick(1);
    for (int k = 0; k < 8; k++) begin
      tick(1);
      check("R8 toggle event", wl_evt_o, 1);
    end
    check("R12 saturated", evt_count_o, EMAX);
    evt_flush_i = 1; tick(1); evt_flush_i = 0;
    check("R12 flush with toggle", evt_count_o, 1);
    tick(1); check("R12 count after flush", evt_count_o, 2);
    enable_i = 0; evt_flush_i = 1; tick(1); evt_flush_i = 0;
    check("R12 idle flush", evt_count_o, 0);

    report();
  end
endmodule